// File: doc/BRIEF.md
# Privilege-Aware Memory Access Checker

This block judges every memory access against two protection schemes at once. The first is a contiguous address window held in a lower and an upper limit register; an address outside that window faults. The second is a set of four permission bits that come with the page from translation. These bits grant reading and writing separately to user code and to kernel code. Each access presented on the access port gets one registered verdict, either allowed or faulted, together with a two-bit cause.

The two limit registers are reached through a small configuration port. Code at any privilege level may read them. Only supervisor code may change them: a user-mode write leaves both registers as they were and reports a privileged-write cause. Typical page setups fall out of the four bits. A code page grants reads only, so writes are refused. Kernel-private data grants nothing to user code. A page-table page lets the kernel write and user code read, but refuses user writes.

Top module: `prot_access_checker`

## Requirements
- R1: After reset the lower limit is 0, the upper limit is all ones, and neither `chk_valid` nor `cfg_rsp_valid` is asserted.
- R2: An access whose address lies between the lower and upper limits, with both ends included, passes the window test. If its permission also holds, the verdict is allow with cause 0.
- R3: An access whose address is below the lower limit or above the upper limit is refused with cause 1. `chk_allow` is 1 exactly when the cause is 0.
- R4: The permission bits are `acc_perm[0]` user read, `acc_perm[1]` user write, `acc_perm[2]` kernel read, `acc_perm[3]` kernel write. The bit chosen by `mode_super` and `acc_is_write` must be 1. Otherwise an in-window access is refused with cause 2.
- R5: When an access is both outside the window and lacks permission, the cause is 1.
- R6: A configuration write with `mode_super` high loads `cfg_wdata` into the selected register: `cfg_sel` 0 is the lower limit and 1 is the upper limit. Accesses use the new value from the next cycle on.
- R7: A configuration write with `mode_super` low leaves both limits unchanged and answers with cause 3. Reads succeed in either mode with cause 0.
- R8: The verdict for an access presented with `acc_valid` appears on `chk_valid`, `chk_allow` and `chk_cause` one cycle later. `chk_valid` is low in the cycle after a cycle without `acc_valid`.
- R9: Every configuration request raises `cfg_rsp_valid` one cycle later. `cfg_rsp_data` then carries the selected register's value from before that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | AW | Access address |
| acc_is_write | input | 1 | 1 for a write access, 0 for a read |
| mode_super | input | 1 | 1 in supervisor mode, 0 in user mode; applies to accesses and configuration requests |
| acc_perm | input | 4 | Page permission bits {kernel write, kernel read, user write, user read} |
| chk_valid | output | 1 | A verdict is present |
| chk_allow | output | 1 | Access allowed |
| chk_cause | output | 2 | 0 allowed, 1 out of window, 2 permission denied |
| cfg_en | input | 1 | Configuration request this cycle |
| cfg_write | input | 1 | 1 write, 0 read |
| cfg_sel | input | 1 | 0 lower limit, 1 upper limit |
| cfg_wdata | input | AW | Value to write |
| cfg_rsp_valid | output | 1 | Configuration response present |
| cfg_rsp_data | output | AW | Register value before the request |
| cfg_rsp_cause | output | 2 | 0 accepted, 3 user-mode write refused |

## Verification
A wrong limit value shows at the ports as a wrong verdict on the next access near a window edge, and as a wrong read-back one cycle after any configuration read. For that reason the stimulus keeps reading the limits back and keeps placing addresses on and just beside both edges. A user-mode write that wrongly gets through is caught on the next read-back or on the next edge access. A permission decode that picks the wrong bit shows in the first verdict for an access with that mode and direction.

// File: rtl/prot_chk_pkg.sv
package prot_chk_pkg;

    typedef enum logic [1:0] {
        CAUSE_OK       = 2'd0,
        CAUSE_BOUNDS   = 2'd1,
        CAUSE_PERM     = 2'd2,
        CAUSE_PRIV_REG = 2'd3
    } cause_e;

    typedef struct packed {
        logic krn_wr;
        logic krn_rd;
        logic usr_wr;
        logic usr_rd;
    } page_perm_t;

    localparam int unsigned PERM_W = $bits(page_perm_t);

    function automatic logic perm_grants(page_perm_t p, logic is_super, logic is_write);
        logic g;
        if (is_super) g = is_write ? p.krn_wr : p.krn_rd;
        else          g = is_write ? p.usr_wr : p.usr_rd;
        return g;
    endfunction

    function automatic cause_e pick_cause(logic out_of_window, logic perm_ok);
        cause_e c;
        if (out_of_window) c = CAUSE_BOUNDS;
        else if (!perm_ok) c = CAUSE_PERM;
        else               c = CAUSE_OK;
        return c;
    endfunction

endpackage

// File: rtl/prot_bounds_regs.sv
module prot_bounds_regs
    import prot_chk_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_en,
    input  logic          cfg_write,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          mode_super,
    output logic [AW-1:0] lim_lo,
    output logic [AW-1:0] lim_hi,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_data,
    output cause_e        rsp_cause
);

    localparam logic [AW-1:0] LO_RST = '0;
    localparam logic [AW-1:0] HI_RST = '1;

    logic wr_ok;
    logic wr_refused;

    assign wr_ok      = cfg_en && cfg_write && mode_super;
    assign wr_refused = cfg_en && cfg_write && !mode_super;

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_lo <= LO_RST;
            lim_hi <= HI_RST;
        end else if (wr_ok) begin
            if (cfg_sel) lim_hi <= cfg_wdata;
            else         lim_lo <= cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_cause <= CAUSE_OK;
        end else begin
            rsp_valid <= cfg_en;
            if (cfg_en) begin
                rsp_data  <= cfg_sel ? lim_hi : lim_lo;
                rsp_cause <= wr_refused ? CAUSE_PRIV_REG : CAUSE_OK;
            end
        end
    end

    assert_user_write_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_write && !mode_super) |=> ($stable(lim_lo) && $stable(lim_hi)
                                                  && rsp_cause == CAUSE_PRIV_REG));

    assert_super_write_lands_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_write && mode_super && !cfg_sel) |=> (lim_lo == $past(cfg_wdata)));

    assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> rsp_valid);

endmodule

// File: rtl/prot_range_cmp.sv
module prot_range_cmp #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lim_lo,
    input  logic [AW-1:0] lim_hi,
    output logic          out_of_window
);

    logic below;
    logic above;

    assign below         = addr < lim_lo;
    assign above         = addr > lim_hi;
    assign out_of_window = below || above;

endmodule

// File: rtl/prot_perm_decode.sv
module prot_perm_decode
    import prot_chk_pkg::*;
(
    input  page_perm_t perm,
    input  logic       is_super,
    input  logic       is_write,
    output logic       perm_ok
);

    assign perm_ok = perm_grants(perm, is_super, is_write);

    always_comb begin
        if (!is_super && !perm.usr_rd && !perm.usr_wr)
            assert_user_locked_out_R4: assert (!perm_ok);
    end

endmodule

// File: rtl/prot_access_checker.sv
module prot_access_checker
    import prot_chk_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_addr,
    input  logic          acc_is_write,
    input  logic          mode_super,
    input  logic [3:0]    acc_perm,
    output logic          chk_valid,
    output logic          chk_allow,
    output logic [1:0]    chk_cause,
    input  logic          cfg_en,
    input  logic          cfg_write,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic          cfg_rsp_valid,
    output logic [AW-1:0] cfg_rsp_data,
    output logic [1:0]    cfg_rsp_cause
);

    logic [AW-1:0] lim_lo;
    logic [AW-1:0] lim_hi;
    logic          oow;
    logic          perm_ok;
    cause_e        cause_d;
    cause_e        cause_q;
    cause_e        rsp_cause_e;
    page_perm_t    perm_s;

    assign perm_s = page_perm_t'(acc_perm);

    prot_bounds_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_en     (cfg_en),
        .cfg_write  (cfg_write),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .mode_super (mode_super),
        .lim_lo     (lim_lo),
        .lim_hi     (lim_hi),
        .rsp_valid  (cfg_rsp_valid),
        .rsp_data   (cfg_rsp_data),
        .rsp_cause  (rsp_cause_e)
    );

    prot_range_cmp #(.AW(AW)) u_range (
        .addr          (acc_addr),
        .lim_lo        (lim_lo),
        .lim_hi        (lim_hi),
        .out_of_window (oow)
    );

    prot_perm_decode u_perm (
        .perm     (perm_s),
        .is_super (mode_super),
        .is_write (acc_is_write),
        .perm_ok  (perm_ok)
    );

    assign cause_d = pick_cause(oow, perm_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_valid <= 1'b0;
            cause_q   <= CAUSE_OK;
        end else begin
            chk_valid <= acc_valid;
            if (acc_valid) cause_q <= cause_d;
        end
    end

    assign chk_cause     = cause_q;
    assign chk_allow     = chk_valid && (cause_q == CAUSE_OK);
    assign cfg_rsp_cause = rsp_cause_e;

    assert_allow_matches_cause_R3: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> (chk_allow == (chk_cause == 2'd0)));

    assert_window_first_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && oow) |=> (chk_cause == 2'd1));

    assert_verdict_timing_R8: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> chk_valid);

    assert_no_spurious_verdict_R8: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !chk_valid);

endmodule

// File: tb/prot_access_checker_bench.sv
module prot_access_checker_bench;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_is_write = 1'b0;
    logic          mode_super = 1'b0;
    logic [3:0]    acc_perm = 4'h0;
    logic          chk_valid, chk_allow;
    logic [1:0]    chk_cause;
    logic          cfg_en = 1'b0, cfg_write = 1'b0, cfg_sel = 1'b0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          cfg_rsp_valid;
    logic [AW-1:0] cfg_rsp_data;
    logic [1:0]    cfg_rsp_cause;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prot_access_checker #(.AW(AW)) u_prot_access_checker (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_is_write(acc_is_write), .mode_super(mode_super), .acc_perm(acc_perm),
        .chk_valid(chk_valid), .chk_allow(chk_allow), .chk_cause(chk_cause),
        .cfg_en(cfg_en), .cfg_write(cfg_write), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_data(cfg_rsp_data), .cfg_rsp_cause(cfg_rsp_cause)
    );

    // reference model state
    logic [AW-1:0] m_lo, m_hi;
    logic          e_valid, e_allow, e_rvalid;
    logic [1:0]    e_cause, e_rcause;
    logic [AW-1:0] e_rdata;

    always @(posedge clk) begin
        if (rst) begin
            m_lo = '0; m_hi = '1;
            e_valid = 0; e_allow = 0; e_cause = 0;
            e_rvalid = 0; e_rdata = '0; e_rcause = 0;
        end else begin
            logic need;
            e_valid = acc_valid;
            if (acc_valid) begin
                if (mode_super) need = acc_is_write ? acc_perm[3] : acc_perm[2];
                else            need = acc_is_write ? acc_perm[1] : acc_perm[0];
                if (acc_addr < m_lo || acc_addr > m_hi) e_cause = 2'd1;
                else if (!need)                         e_cause = 2'd2;
                else                                    e_cause = 2'd0;
                e_allow = (e_cause == 2'd0);
            end
            e_rvalid = cfg_en;
            if (cfg_en) begin
                e_rdata  = cfg_sel ? m_hi : m_lo;
                e_rcause = (cfg_write && !mode_super) ? 2'd3 : 2'd0;
                if (cfg_write && mode_super) begin
                    if (cfg_sel) m_hi = cfg_wdata;
                    else         m_lo = cfg_wdata;
                end
            end
        end
    end

    task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag_of(logic [1:0] c);
        case (c)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R7";
        endcase
    endfunction

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst) begin
            // R1: no responses while in reset
            check("R1 chk_valid", {31'b0, chk_valid}, 32'd0);
            check("R1 cfg_rsp_valid", {31'b0, cfg_rsp_valid}, 32'd0);
        end else if (!done) begin
            check("R8 chk_valid", {31'b0, chk_valid}, {31'b0, e_valid});
            if (e_valid) begin
                check(tag_of(e_cause), {30'b0, chk_cause}, {30'b0, e_cause});
                check("R3 allow", {31'b0, chk_allow}, {31'b0, e_allow});
            end
            check("R9 rsp_valid", {31'b0, cfg_rsp_valid}, {31'b0, e_rvalid});
            if (e_rvalid) begin
                check("R9 rsp_data", cfg_rsp_data, e_rdata);
                check(e_rcause == 2'd3 ? "R7 cause" : "R6 cause",
                      {30'b0, cfg_rsp_cause}, {30'b0, e_rcause});
            end
        end
    end

    task automatic idle();
        acc_valid = 0; cfg_en = 0;
        @(negedge clk);
    endtask

    task automatic acc(logic [AW-1:0] a, logic wr, logic sup, logic [3:0] p);
        acc_valid = 1; cfg_en = 0;
        acc_addr = a; acc_is_write = wr; mode_super = sup; acc_perm = p;
        @(negedge clk);
        acc_valid = 0;
    endtask

    task automatic cfg(logic wr, logic sel, logic sup, logic [AW-1:0] d);
        cfg_en = 1; acc_valid = 0;
        cfg_write = wr; cfg_sel = sel; mode_super = sup; cfg_wdata = d;
        @(negedge clk);
        cfg_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset values read back in user mode
        cfg(0, 0, 0, '0);
        cfg(0, 1, 0, '0);
        idle();
        // R2: whole space open after reset, both extremes
        acc(32'h0, 0, 0, 4'b0001);
        acc(32'hFFFF_FFFF, 1, 1, 4'b1000);
        // R6: supervisor sets a window
        cfg(1, 0, 1, 32'h0000_1000);
        cfg(1, 1, 1, 32'h0000_1FFF);
        cfg(0, 0, 0, '0);
        cfg(0, 1, 0, '0);
        // R2 / R3: edges of the window
        acc(32'h0000_0FFF, 0, 0, 4'hF);
        acc(32'h0000_1000, 0, 0, 4'hF);
        acc(32'h0000_1FFF, 1, 1, 4'hF);
        acc(32'h0000_2000, 1, 1, 4'hF);
        // R7: user write refused, limits unchanged
        cfg(1, 0, 0, 32'h0000_0000);
        cfg(1, 1, 0, 32'hFFFF_FFFF);
        cfg(0, 0, 1, '0);
        cfg(0, 1, 0, '0);
        acc(32'h0000_0FFF, 0, 1, 4'hF);
        // R4: code page (user read, kernel read) refuses writes
        acc(32'h0000_1800, 1, 0, 4'b0101);
        acc(32'h0000_1800, 1, 1, 4'b0101);
        acc(32'h0000_1800, 0, 0, 4'b0101);
        // R4: kernel-private data refuses user read and write
        acc(32'h0000_1800, 0, 0, 4'b1100);
        acc(32'h0000_1800, 1, 0, 4'b1100);
        acc(32'h0000_1800, 1, 1, 4'b1100);
        // R4: page-table page, kernel write and user read allowed, user write refused
        acc(32'h0000_1800, 1, 1, 4'b1101);
        acc(32'h0000_1800, 0, 0, 4'b1101);
        acc(32'h0000_1800, 1, 0, 4'b1101);
        // R5: outside window and no permission
        acc(32'h0000_3000, 1, 0, 4'b0000);
        acc(32'h0000_0010, 0, 1, 4'b0000);
        // R8: gap cycles
        idle(); idle();
        // mixed traffic around the window edges
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] base;
            int k;
            k = $urandom_range(0, 5);
            base = (k < 2) ? 32'h0000_1000 : (k < 4) ? 32'h0000_1FFF : $urandom;
            acc_valid = $urandom_range(0, 3) != 0;
            acc_addr = base + AW'($urandom_range(0, 2)) - 32'd1;
            acc_is_write = $urandom_range(0, 1) == 1;
            acc_perm = 4'($urandom_range(0, 15));
            mode_super = $urandom_range(0, 1) == 1;
            cfg_en = $urandom_range(0, 5) == 0;
            cfg_write = $urandom_range(0, 1) == 1;
            cfg_sel = $urandom_range(0, 1) == 1;
            cfg_wdata = (cfg_sel ? 32'h0000_1FFF : 32'h0000_1000) + AW'($urandom_range(0, 4)) - 32'd2;
            @(negedge clk);
        end
        idle(); idle();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule